// File: doc/BRIEF.md
# Lock-Gated GPIO Pad Mode Controller

This block is a memory-mapped general-purpose I/O port of up to 32 pins. Each pin is described by two mode bits (an upper bit and a lower bit) and one output data bit. Together these three bits choose between four pad behaviours: a pure input, a full push-pull driver, a driver that can only pull low, and a driver that can only pull high. From these bits the block produces a drive value and an output enable for every pad. It also samples the pad inputs through a two-flop synchroniser into a readable data-in register.

The direction of a pad can only change through the mode registers, and those registers are guarded by a key register. Software arms the key register by writing a 16-bit magic value. While the lock is active, the mode registers accept whole-register loads and per-bit set or clear writes. While it is inactive, every mode write is dropped. The output data bits are not guarded. They are changed through separate set and clear addresses, and each of those writes touches only the bits written as 1.

Reads are combinational from the current address. Writes take effect on the next rising clock edge.

Top module: `gpio_mode_ctl`

## Requirements
- R1: After reset the lock is inactive, every mode bit is 0, every output data bit is 0, and no pad is driven (padOe all 0, padOut all 0).
- R2: A write to the key register at offset 0x00 whose bits 15:0 equal 0xD42F makes the lock active from the next cycle. A read of offset 0x00 returns bit 31 as the lock status, and all its other bits read 0.
- R3: A key-register write with bits 15:0 equal to 0 releases the lock. A key-register write with any other value leaves the lock status unchanged.
- R4: While the lock is inactive, writes to the mode addresses 0x08, 0x0C, 0x50, 0x54 and 0x58 change no mode bit.
- R5: While the lock is active, the following writes act on the mode registers, and the new values read back at 0x08 (upper mode bits) and 0x0C (lower mode bits) from the next cycle. A write to 0x0C loads the whole lower mode register. A write to 0x08 loads the whole upper mode register. A write to 0x54 sets, and a write to 0x58 clears, only those lower mode bits written as 1. A write to 0x50 clears only those upper mode bits written as 1.
- R6: A pin with mode {upper,lower} = 00 is never driven, whatever its data bit.
- R7: A pin with mode 01 is driven (padOe=1), and padOut equals its data bit.
- R8: A pin with mode 10 drives low when its data bit is 0 and is not driven when its data bit is 1.
- R9: A pin with mode 11 is not driven when its data bit is 0 and drives high when its data bit is 1. For every pin in every mode, padOut is 0 whenever padOe is 0.
- R10: A write to 0x14 sets, and a write to 0x18 clears, only those output data bits written as 1, whatever the lock state. Reads of 0x14 and 0x18 return the output data register.
- R11: A read of 0x04 returns padIn after the two-flop synchroniser, so a pad change is visible after the second rising edge. Bits at and above NUM_PINS read 0 in every register, and write-data bits for those positions are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the current address (combinational) |
| padIn | input | NUM_PINS | Pad input levels |
| padOut | output | NUM_PINS | Pad drive values |
| padOe | output | NUM_PINS | Pad output enables |

## Verification
The bench builds the block with NUM_PINS set to 20, not the default 32. This leaves twelve unimplemented positions in every register, so masking can be observed. With these positions present, the bench can show that full-width loads, set and clear writes, and data-in reads keep the upper bits at zero. Four pins are placed in the four different modes at once, so a single data pattern exercises every branch of the pad decode. A full-width write of 1s to the upper mode register shows that only the implemented bits respond.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_LOCK      = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIN       = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MODE_HI   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MODE_LO   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DATA_SET  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DATA_CLR  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_HI_CLR    = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_LO_SET    = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_LO_CLR    = 8'h58;

  typedef struct packed {
    logic hiLoad;
    logic loLoad;
    logic hiClr;
    logic loSet;
    logic loClr;
    logic dataSet;
    logic dataClr;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_LOCK, RD_DIN, RD_MODE_HI, RD_MODE_LO, RD_DATA
  } rdsel_t;
endpackage

// File: rtl/gpio_mode_ctrl.sv
module gpio_mode_ctrl
  import gpio_mode_pkg::*;
#(
  parameter int          KEY_W      = 16,
  parameter logic [15:0] UNLOCK_KEY = 16'hD42F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output strobe_t           stb,
  output rdsel_t            rdSel,
  output logic              lockActive
);
  logic [KEY_W-1:0] keyField;
  logic             keyWr;
  logic             modeOk;

  assign keyField = wrData[KEY_W-1:0];
  assign keyWr    = wrEn && (addr == OFS_LOCK);
  assign modeOk   = wrEn && lockActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockActive <= 1'b0;
    end else if (keyWr) begin
      if (keyField == UNLOCK_KEY[KEY_W-1:0]) lockActive <= 1'b1;
      else if (keyField == '0)               lockActive <= 1'b0;
    end
  end

  always_comb begin
    stb         = '0;
    stb.hiLoad  = modeOk && (addr == OFS_MODE_HI);
    stb.loLoad  = modeOk && (addr == OFS_MODE_LO);
    stb.hiClr   = modeOk && (addr == OFS_HI_CLR);
    stb.loSet   = modeOk && (addr == OFS_LO_SET);
    stb.loClr   = modeOk && (addr == OFS_LO_CLR);
    stb.dataSet = wrEn && (addr == OFS_DATA_SET);
    stb.dataClr = wrEn && (addr == OFS_DATA_CLR);
  end

  always_comb begin
    unique case (addr)
      OFS_LOCK:                   rdSel = RD_LOCK;
      OFS_DIN:                    rdSel = RD_DIN;
      OFS_MODE_HI:                rdSel = RD_MODE_HI;
      OFS_MODE_LO:                rdSel = RD_MODE_LO;
      OFS_DATA_SET, OFS_DATA_CLR: rdSel = RD_DATA;
      default:                    rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_mode_dp.sv
module gpio_mode_dp
  import gpio_mode_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  rdsel_t              rdSel,
  input  logic                lockActive,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [BUS_W-1:0]    rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] mode0Q,
  output logic [NUM_PINS-1:0] mode1Q,
  output logic [NUM_PINS-1:0] dataQ
);
  logic [NUM_PINS-1:0] wrPins;
  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] syncB;

  assign wrPins = wrData[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode0Q <= '0;
      mode1Q <= '0;
      dataQ  <= '0;
      syncA  <= '0;
      syncB  <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (stb.loLoad)      mode0Q <= wrPins;
      else if (stb.loSet)  mode0Q <= mode0Q | wrPins;
      else if (stb.loClr)  mode0Q <= mode0Q & ~wrPins;
      if (stb.hiLoad)      mode1Q <= wrPins;
      else if (stb.hiClr)  mode1Q <= mode1Q & ~wrPins;
      if (stb.dataSet)     dataQ <= dataQ | wrPins;
      else if (stb.dataClr) dataQ <= dataQ & ~wrPins;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic driveOn;
    logic driveVal;
    always_comb begin
      unique case ({mode1Q[p], mode0Q[p]})
        2'b01:   begin driveOn = 1'b1;      driveVal = dataQ[p]; end
        2'b10:   begin driveOn = ~dataQ[p]; driveVal = 1'b0;     end
        2'b11:   begin driveOn = dataQ[p];  driveVal = 1'b1;     end
        default: begin driveOn = 1'b0;      driveVal = 1'b0;     end
      endcase
    end
    assign padOe[p]  = driveOn;
    assign padOut[p] = driveOn & driveVal;
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_LOCK:    rdData[BUS_W-1]    = lockActive;
      RD_DIN:     rdData[NUM_PINS-1:0] = syncB;
      RD_MODE_HI: rdData[NUM_PINS-1:0] = mode1Q;
      RD_MODE_LO: rdData[NUM_PINS-1:0] = mode0Q;
      RD_DATA:    rdData[NUM_PINS-1:0] = dataQ;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mode_ctl.sv
module gpio_mode_ctl
  import gpio_mode_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [7:0]          addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  strobe_t             stb;
  rdsel_t              rdSel;
  logic                lockActive;
  logic [NUM_PINS-1:0] mode0Q;
  logic [NUM_PINS-1:0] mode1Q;
  logic [NUM_PINS-1:0] dataQ;

  gpio_mode_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .stb        (stb),
    .rdSel      (rdSel),
    .lockActive (lockActive)
  );

  gpio_mode_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .lockActive (lockActive),
    .wrData     (wrData),
    .padIn      (padIn),
    .rdData     (rdData),
    .padOut     (padOut),
    .padOe      (padOe),
    .mode0Q     (mode0Q),
    .mode1Q     (mode1Q),
    .dataQ      (dataQ)
  );
endmodule

// File: rtl/gpio_mode_chk.sv
module gpio_mode_chk
  import gpio_mode_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [7:0]          addr,
  input logic [31:0]         wrData,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                lockActive,
  input logic [NUM_PINS-1:0] mode0Q,
  input logic [NUM_PINS-1:0] mode1Q,
  input logic [NUM_PINS-1:0] dataQ
);
  logic modeAddr;
  assign modeAddr = (addr == OFS_MODE_HI) || (addr == OFS_MODE_LO) ||
                    (addr == OFS_HI_CLR) || (addr == OFS_LO_SET) ||
                    (addr == OFS_LO_CLR);

  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_LOCK && wrData[15:0] == 16'hD42F) |=> lockActive);

  a_r3_zero_releases: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_LOCK && wrData[15:0] == 16'h0000) |=> !lockActive);

  a_r4_locked_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && modeAddr && !lockActive) |=> ($stable(mode0Q) && $stable(mode1Q)));

  a_r6_input_undriven: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~(mode0Q | mode1Q)) == '0);

  a_r8_open_low_never_high: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & mode1Q & ~mode0Q) == '0);

  a_r10_data_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_DATA_SET) |=>
      (dataQ == ($past(dataQ) | $past(wrData[NUM_PINS-1:0]))));
endmodule

bind gpio_mode_ctl gpio_mode_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .padOut     (padOut),
  .padOe      (padOe),
  .lockActive (lockActive),
  .mode0Q     (mode0Q),
  .mode1Q     (mode1Q),
  .dataQ      (dataQ)
);

// File: tb/tb_gpio_mode_ctl.sv
`timescale 1ns/1ps
module tb_gpio_mode_ctl;
  localparam int NP = 20;
  localparam logic [31:0] PMASK = (32'h1 << NP) - 1;

  logic          clk = 0;
  logic          rstN = 0;
  logic          wrEn = 0;
  logic [7:0]    addr = 0;
  logic [31:0]   wrData = 0;
  logic [31:0]   rdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut;
  logic [NP-1:0] padOe;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_mode_ctl #(.NUM_PINS(NP)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; addr = 8'hFC; wrData = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
    addr = 8'hFC;
  endtask

  function automatic void expPad(input logic [NP-1:0] m1, input logic [NP-1:0] m0,
                                 input logic [NP-1:0] dt,
                                 output logic [NP-1:0] oe, output logic [NP-1:0] ov);
    for (int i = 0; i < NP; i++) begin
      case ({m1[i], m0[i]})
        2'b01:   begin oe[i] = 1'b1;    ov[i] = dt[i]; end
        2'b10:   begin oe[i] = ~dt[i];  ov[i] = 1'b0;  end
        2'b11:   begin oe[i] = dt[i];   ov[i] = dt[i]; end
        default: begin oe[i] = 1'b0;    ov[i] = 1'b0;  end
      endcase
    end
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    busRd(8'h00, v); chk("R1 lock after reset", v, 32'h0);
    busRd(8'h0C, v); chk("R1 lower mode after reset", v, 32'h0);
    busRd(8'h08, v); chk("R1 upper mode after reset", v, 32'h0);
    busRd(8'h14, v); chk("R1 data after reset", v, 32'h0);
    chk("R1 padOe after reset", 32'(padOe), 32'h0);
    chk("R1 padOut after reset", 32'(padOut), 32'h0);
  endtask

  task automatic t_lock_gate();
    logic [31:0] v;
    busWr(8'h0C, 32'hFFFF_FFFF);
    busWr(8'h54, 32'h0000_0001);
    busWr(8'h08, 32'h0000_0001);
    busRd(8'h0C, v); chk("R4 lower mode locked", v, 32'h0);
    busRd(8'h08, v); chk("R4 upper mode locked", v, 32'h0);
    chk("R4 pads untouched while locked", 32'(padOe), 32'h0);
    busWr(8'h00, 32'h0000_1234);
    busRd(8'h00, v); chk("R3 wrong key does not arm", v, 32'h0);
    busWr(8'h00, 32'h0000_D42F);
    busRd(8'h00, v); chk("R2 key arms lock", v, 32'h8000_0000);
    busWr(8'h00, 32'h0000_5A5A);
    busRd(8'h00, v); chk("R3 other value keeps lock", v, 32'h8000_0000);
    busWr(8'h0C, 32'h0000_0010);
    busWr(8'h00, 32'h0000_0000);
    busRd(8'h00, v); chk("R3 zero releases lock", v, 32'h0);
    busWr(8'h58, 32'h0000_0010);
    busRd(8'h0C, v); chk("R4 clear ignored after release", v, 32'h0000_0010);
    busWr(8'h0C, 32'h0);
  endtask

  task automatic t_mode_setclr();
    logic [31:0] v;
    busWr(8'h00, 32'h0000_D42F);
    busWr(8'h0C, 32'h0);
    busWr(8'h0C, 32'h0000_00F0);
    busRd(8'h0C, v); chk("R5 lower load", v, 32'h0000_00F0);
    busWr(8'h54, 32'h0000_0003);
    busRd(8'h0C, v); chk("R5 lower set", v, 32'h0000_00F3);
    busWr(8'h58, 32'h0000_0030);
    busRd(8'h0C, v); chk("R5 lower clear", v, 32'h0000_00C3);
    busWr(8'h08, 32'hFFFF_FFFF);
    busRd(8'h08, v); chk("R11 upper load masked to pins", v, PMASK);
    busWr(8'h50, 32'h000F_FFF0);
    busRd(8'h08, v); chk("R5 upper clear", v, 32'h0000_000F);
  endtask

  task automatic t_pad_decode();
    logic [NP-1:0] eo, ev;
    busWr(8'h18, 32'hFFFF_FFFF);
    busWr(8'h08, 32'h0000_000C);
    busWr(8'h0C, 32'h0000_000A);
    expPad(20'hC, 20'hA, 20'h0, eo, ev);
    chk("R6 R7 R8 R9 padOe data=0", 32'(padOe), 32'(eo));
    chk("R7 R9 padOut data=0", 32'(padOut), 32'(ev));
    chk("R8 open-low drives pin2 data=0", 32'(padOe & 20'h4), 32'h4);
    busWr(8'h14, 32'h0000_000F);
    expPad(20'hC, 20'hA, 20'hF, eo, ev);
    chk("R6 R7 R8 R9 padOe data=1", 32'(padOe), 32'(eo));
    chk("R7 R9 padOut data=1", 32'(padOut), 32'(ev));
    chk("R6 input pin0 undriven", 32'(padOe & 20'h1), 32'h0);
    busWr(8'h18, 32'h0000_0002);
    expPad(20'hC, 20'hA, 20'hD, eo, ev);
    chk("R7 full drive follows data", 32'(padOe), 32'(eo));
    chk("R7 full drive low value", 32'(padOut), 32'(ev));
  endtask

  task automatic t_data_setclr();
    logic [31:0] v;
    busWr(8'h00, 32'h0000_0000);
    busWr(8'h18, 32'hFFFF_FFFF);
    busWr(8'h14, 32'hFFF0_0A0A);
    busRd(8'h14, v); chk("R10 set while unlocked, masked", v, 32'h0000_0A0A);
    busWr(8'h18, 32'h0000_0808);
    busRd(8'h18, v); chk("R10 clear only written bits", v, 32'h0000_0202);
    busWr(8'h14, 32'h0000_0000);
    busRd(8'h14, v); chk("R10 set of zeros no effect", v, 32'h0000_0202);
  endtask

  task automatic t_datain();
    logic [31:0] v;
    @(negedge clk);
    padIn = 20'hA5A5A;
    @(negedge clk);
    busRd(8'h04, v); chk("R11 data-in not yet after one edge", v, 32'h0);
    @(negedge clk);
    busRd(8'h04, v); chk("R11 data-in after two edges", v, 32'h000A_5A5A);
    padIn = '1;
    repeat (2) @(negedge clk);
    busRd(8'h04, v); chk("R11 data-in upper bits read 0", v, PMASK);
  endtask

  initial begin
    #1_600_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    addr = 8'hFC;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_lock_gate();
    t_mode_setclr();
    t_pad_decode();
    t_data_setclr();
    t_datain();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule